// File: doc/BRIEF.md
# Multi-Source Reset Supervisor Controller

This block sequences the reset line of a processor from several independent causes. Three "supply good" flags come from external voltage comparators: primary, secondary and adjustable. A push-button input is active low, and a strap selects how the button is qualified. The block drives a registered, active-low reset output. Any supply flag going bad, or a qualified button press, pulls the reset low. The reset is released only after every cause has cleared and a single release timeout has run out without interruption.

Every external input passes through a two-flop synchronizer. The button then goes through a run-length qualifier with two settings. In immediate mode, a short filter window rejects glitches. In delayed mode, the button must be held for a much longer interval, and releasing it early cancels the press. A one-hot cause register records which cause started the most recent reset assertion. All intervals are parameters counted in clock cycles. The defaults assume a 4 ns clock: 52,500,000 cycles for the release timeout (210 ms), 32 cycles for the glitch window (128 ns) and 1500 cycles for the long press (6 us).

Top module: `rstseq_top`

## Requirements
- R1: A supply flag that reads low at two consecutive clock edges drives `rst_n_o` low at the third edge.
- R2: While `arst_n` is low, `rst_n_o` is 0 and `cause_o` is 4'b0000.
- R3: After `arst_n` is released with all supplies good and the button released, `rst_n_o` stays low and rises at the edge `TIMEOUT_CYC + 2` cycles after the release.
- R4: After the last remaining cause goes away at the pins, `rst_n_o` rises exactly `TIMEOUT_CYC + 2` edges later. This holds whether the cause was a supply flag returning high or the button returning high.
- R5: If any cause reappears while the release timeout is running, `rst_n_o` stays low and the timeout restarts in full once all causes clear again.
- R6: In immediate mode (`mr_delay_i` = 0), a low pulse on `mr_n_i` shorter than `FILT_CYC` cycles has no effect. A low level lasting `FILT_CYC` cycles drives `rst_n_o` low `FILT_CYC + 2` edges after the falling input.
- R7: In delayed mode (`mr_delay_i` = 1), the button must be held low for `LONG_CYC` cycles, and reset then falls `LONG_CYC + 2` edges after the press. A release before that has no effect.
- R8: A qualified button press keeps `rst_n_o` low for as long as the button stays low.
- R9: `cause_o` is one-hot, with bit 0 for primary, bit 1 for secondary, bit 2 for adjustable and bit 3 for the button. It loads on the same edge that a cause appears after a cause-free cycle. When several causes appear together, the lowest bit wins. It holds its value until the next such event and never changes while `rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low block reset (power-on) |
| pri_ok_i | input | 1 | Primary supply good flag, 1 = above threshold |
| sec_ok_i | input | 1 | Secondary supply good flag, 1 = above threshold |
| adj_ok_i | input | 1 | Adjustable supply good flag, 1 = above threshold |
| mr_n_i | input | 1 | Push-button input, active low, 1 when unused |
| mr_delay_i | input | 1 | Qualification strap: 0 = glitch filter, 1 = long press |
| rst_n_o | output | 1 | Registered active-low reset to the processor |
| cause_o | output | 4 | One-hot cause of the latest reset assertion, 0 after block reset |

## Verification
The bench counts latency from the clock edge that first samples an input change, and it adds the two synchronizer stages in every case. A supply drop shows up on the reset pin 3 cycles later. A button press shows up `FILT_CYC + 2` or `LONG_CYC + 2` cycles later, depending on the mode. The release comes `TIMEOUT_CYC + 2` cycles after the last cause goes away at the pins. The driver task records the cycle at which it changes an input and queues each expected reset and cause value against an absolute cycle number. The monitor compares on the falling clock edge of exactly that cycle, so each check sees the result one cycle before and one cycle at the moment it is due.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int CAUSE_N   = 4;
   localparam int CAUSE_PRI = 0;
   localparam int CAUSE_SEC = 1;
   localparam int CAUSE_ADJ = 2;
   localparam int CAUSE_BTN = 3;
   typedef logic [CAUSE_N-1:0] cause_vec_t;
   // synchronizer start values: supplies assumed bad, button released
   localparam cause_vec_t SYNC_START = 4'b1000;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int             W       = 4,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            meta_q <= RST_VAL[i];
            stab_q <= RST_VAL[i];
         end else begin
            meta_q <= d_i[i];
            stab_q <= meta_q;
         end
      end
      assign q_o[i] = stab_q;
   end
endmodule

// File: rtl/rstseq_btn.sv
module rstseq_btn #(
   parameter int FILT_CYC = 32,
   parameter int LONG_CYC = 1500
) (
   input  logic clk,
   input  logic arst_n,
   input  logic btn_low_i,
   input  logic long_sel_i,
   output logic press_o
);
   localparam int LIMIT = (LONG_CYC > FILT_CYC) ? LONG_CYC : FILT_CYC;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] FILT_M1 = CW'(FILT_CYC - 1);
   localparam logic [CW-1:0] LONG_M1 = CW'(LONG_CYC - 1);
   localparam logic [CW-1:0] SAT     = CW'(LIMIT);

   logic [CW-1:0] run_q;
   logic [CW-1:0] need_m1;

   assign need_m1 = long_sel_i ? LONG_M1 : FILT_M1;

   // counts low cycles already seen; current cycle completes the run
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         run_q <= '0;
      else if (!btn_low_i)
         run_q <= '0;
      else if (run_q != SAT)
         run_q <= run_q + 1'b1;
   end

   assign press_o = btn_low_i && (run_q >= need_m1);
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [N-1:0] src_i,
   output logic         any_o,
   output logic [N-1:0] cause_o
);
   logic         seen_q;
   logic [N-1:0] lowest;

   assign any_o  = |src_i;
   assign lowest = src_i & (~src_i + N'(1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         seen_q  <= 1'b1;
         cause_o <= '0;
      end else begin
         seen_q <= any_o;
         if (any_o && !seen_q)
            cause_o <= lowest;
      end
   end
endmodule

// File: rtl/rstseq_release.sv
module rstseq_release #(
   parameter int TIMEOUT_CYC = 52_500_000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic hold_i,
   output logic rst_n_o
);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [TW-1:0] DONE = TW'(TIMEOUT_CYC);

   logic [TW-1:0] quiet_q, quiet_d;

   always_comb begin
      if (hold_i)
         quiet_d = '0;
      else if (quiet_q == DONE)
         quiet_d = DONE;
      else
         quiet_d = quiet_q + 1'b1;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         quiet_q <= '0;
         rst_n_o <= 1'b0;
      end else begin
         quiet_q <= quiet_d;
         rst_n_o <= (quiet_d == DONE);
      end
   end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int TIMEOUT_CYC = 52_500_000,
   parameter int FILT_CYC    = 32,
   parameter int LONG_CYC    = 1500
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         pri_ok_i,
   input  logic         sec_ok_i,
   input  logic         adj_ok_i,
   input  logic         mr_n_i,
   input  logic         mr_delay_i,
   output logic         rst_n_o,
   output logic [3:0]   cause_o
);
   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("rstseq_top: TIMEOUT_CYC must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("rstseq_top: FILT_CYC must be at least 1");
   end
   if (LONG_CYC < FILT_CYC) begin : g_bad_long
      $error("rstseq_top: LONG_CYC must not be below FILT_CYC");
   end

   cause_vec_t raw, synced, src;
   logic       btn_press;
   logic       cause_any;

   assign raw = {mr_n_i, adj_ok_i, sec_ok_i, pri_ok_i};

   rstseq_sync #(.W(CAUSE_N), .RST_VAL(SYNC_START)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d_i    (raw),
      .q_o    (synced)
   );

   rstseq_btn #(.FILT_CYC(FILT_CYC), .LONG_CYC(LONG_CYC)) u_btn (
      .clk        (clk),
      .arst_n     (arst_n),
      .btn_low_i  (!synced[CAUSE_BTN]),
      .long_sel_i (mr_delay_i),
      .press_o    (btn_press)
   );

   assign src[CAUSE_PRI] = !synced[CAUSE_PRI];
   assign src[CAUSE_SEC] = !synced[CAUSE_SEC];
   assign src[CAUSE_ADJ] = !synced[CAUSE_ADJ];
   assign src[CAUSE_BTN] = btn_press;

   rstseq_cause #(.N(CAUSE_N)) u_cause (
      .clk     (clk),
      .arst_n  (arst_n),
      .src_i   (src),
      .any_o   (cause_any),
      .cause_o (cause_o)
   );

   rstseq_release #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_release (
      .clk     (clk),
      .arst_n  (arst_n),
      .hold_i  (cause_any),
      .rst_n_o (rst_n_o)
   );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int TIMEOUT_CYC = 52_500_000
) (
   input logic       clk,
   input logic       arst_n,
   input logic       pri_ok_i,
   input logic       sec_ok_i,
   input logic       adj_ok_i,
   input logic       rst_n_o,
   input logic [3:0] cause_o,
   input logic       cause_any
);
   localparam int QW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC);

   logic [QW-1:0] calm_q;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         calm_q <= '0;
      else if (cause_any)
         calm_q <= '0;
      else if (calm_q != QMAX)
         calm_q <= calm_q + 1'b1;
   end

   a_r1_primary: assert property (@(posedge clk) disable iff (!arst_n)
      (!pri_ok_i && $past(!pri_ok_i)) |-> ##2 !rst_n_o);
   a_r1_secondary: assert property (@(posedge clk) disable iff (!arst_n)
      (!sec_ok_i && $past(!sec_ok_i)) |-> ##2 !rst_n_o);
   a_r1_adjustable: assert property (@(posedge clk) disable iff (!arst_n)
      (!adj_ok_i && $past(!adj_ok_i)) |-> ##2 !rst_n_o);
   a_r4_full_quiet: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_o) |-> (calm_q == QMAX));
   a_r5_no_early_release: assert property (@(posedge clk) disable iff (!arst_n)
      rst_n_o |-> (calm_q == QMAX));
   a_r9_onehot: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(cause_o));
   a_r9_moves_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
      !$stable(cause_o) |-> !rst_n_o);
endmodule

bind rstseq_top rstseq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk       (clk),
   .arst_n    (arst_n),
   .pri_ok_i  (pri_ok_i),
   .sec_ok_i  (sec_ok_i),
   .adj_ok_i  (adj_ok_i),
   .rst_n_o   (rst_n_o),
   .cause_o   (cause_o),
   .cause_any (cause_any)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
   localparam int T = 40;
   localparam int F = 8;
   localparam int L = 30;

   logic clk = 1'b0, arst_n = 1'b0;
   logic pri = 1'b1, sec = 1'b1, adj = 1'b1, btn = 1'b1, mode = 1'b0;
   logic rst_n;
   logic [3:0] cause;

   always #2 clk = ~clk;

   rstseq_top #(.TIMEOUT_CYC(T), .FILT_CYC(F), .LONG_CYC(L)) u_rstseq_top (
      .clk(clk), .arst_n(arst_n), .pri_ok_i(pri), .sec_ok_i(sec), .adj_ok_i(adj),
      .mr_n_i(btn), .mr_delay_i(mode), .rst_n_o(rst_n), .cause_o(cause)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;

   typedef struct {
      int         at;
      logic       r;
      logic [3:0] c;
      string      tag;
   } exp_t;
   exp_t sb[$];

   task automatic exp_push(int dt, logic r, logic [3:0] c, string tag);
      exp_t e;
      e.at = cyc + dt; e.r = r; e.c = c; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_now(logic r, logic [3:0] c, string tag);
      checks++;
      if (rst_n !== r || cause !== c) begin
         errors++;
         $display("FAIL %s: rst_n=%b cause=%b expected rst_n=%b cause=%b", tag, rst_n, cause, r, c);
      end
   endtask

   // monitor: compares queued expectations in their due cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (e.at != cyc || rst_n !== e.r || cause !== e.c) begin
            errors++;
            $display("FAIL %s cycle %0d (due %0d): rst_n=%b cause=%b expected rst_n=%b cause=%b",
                     e.tag, cyc, e.at, rst_n, cause, e.r, e.c);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      check_now(1'b0, 4'b0000, "R2 reset state");
      arst_n = 1'b1;
      exp_push(T + 1, 1'b0, 4'b0000, "R3 still held");
      exp_push(T + 2, 1'b1, 4'b0000, "R3 first release");
      drain();

      // R1 / R4 / R9: secondary drop then recovery
      step(2);
      sec = 1'b0;
      exp_push(2, 1'b1, 4'b0000, "R1 not yet");
      exp_push(3, 1'b0, 4'b0010, "R1 R9 secondary");
      step(10);
      sec = 1'b1;
      exp_push(T + 1, 1'b0, 4'b0010, "R4 hold");
      exp_push(T + 2, 1'b1, 4'b0010, "R4 release");
      drain();

      // R5: re-assertion during timeout restarts it
      step(2);
      adj = 1'b0;
      exp_push(3, 1'b0, 4'b0100, "R1 adjustable");
      step(10);
      adj = 1'b1;
      step(20);
      exp_push(1, 1'b0, 4'b0100, "R5 counting");
      pri = 1'b0;
      exp_push(3, 1'b0, 4'b0001, "R5 R9 new cause");
      step(5);
      pri = 1'b1;
      exp_push(T + 1, 1'b0, 4'b0001, "R5 restart hold");
      exp_push(T + 2, 1'b1, 4'b0001, "R5 restart release");
      drain();

      // R6: glitch one cycle too short
      step(2);
      btn = 1'b0;
      exp_push(F + 3, 1'b1, 4'b0001, "R6 glitch ignored");
      exp_push(F + 6, 1'b1, 4'b0001, "R6 glitch ignored late");
      step(F - 1);
      btn = 1'b1;
      drain();

      // R6 / R8: exactly the filter length
      step(2);
      btn = 1'b0;
      exp_push(F + 1, 1'b1, 4'b0001, "R6 before assert");
      exp_push(F + 2, 1'b0, 4'b1000, "R6 accepted");
      step(F);
      btn = 1'b1;
      exp_push(T + 1, 1'b0, 4'b1000, "R4 button hold");
      exp_push(T + 2, 1'b1, 4'b1000, "R4 button release");
      drain();

      // R7: delayed mode, early release cancels
      mode = 1'b1;
      step(2);
      btn = 1'b0;
      exp_push(L + 4, 1'b1, 4'b1000, "R7 early release ignored");
      step(L - 1);
      btn = 1'b1;
      drain();

      // R7 / R8: long hold
      step(2);
      btn = 1'b0;
      exp_push(L + 1, 1'b1, 4'b1000, "R7 before long press");
      exp_push(L + 2, 1'b0, 4'b1000, "R7 long press");
      step(L + 12);
      exp_push(1, 1'b0, 4'b1000, "R8 held");
      btn = 1'b1;
      exp_push(T + 1, 1'b0, 4'b1000, "R8 hold after release");
      exp_push(T + 2, 1'b1, 4'b1000, "R8 release");
      drain();
      mode = 1'b0;

      // R9: priority and no reload while a cause persists
      step(2);
      sec = 1'b0;
      adj = 1'b0;
      exp_push(3, 1'b0, 4'b0010, "R9 priority");
      step(6);
      pri = 1'b0;
      exp_push(3, 1'b0, 4'b0010, "R9 no reload");
      step(6);
      pri = 1'b1; sec = 1'b1; adj = 1'b1;
      exp_push(T + 1, 1'b0, 4'b0010, "R4 multi hold");
      exp_push(T + 2, 1'b1, 4'b0010, "R4 multi release");
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule